// File: doc/BRIEF.md
# Dual-Group Clock Divider with Phase Offset

The block turns one fast input clock into two groups of divided clock levels, five outputs per group. Each group runs at the input rate divided by its own ratio. The ratio comes from a fixed set that includes non-power-of-two values. Outputs are plain levels, sampled in the input clock domain, so a downstream consumer can use them as clock enables or as a reference waveform. Every output has its own enable. An output that is switched back on waits for the start of its group's next divided period, so it never produces a shortened pulse.

Group 1 can be shifted against group 0 by a programmable number of phase steps. A step is one input cycle when the group 1 ratio is not a multiple of 5. It is five input cycles when the ratio is a multiple of 5. Any accepted ratio write, and any offset write, restarts both group counters together, so the two groups always hold the programmed relation. Configuration arrives through a one-cycle parallel write strobe with a small address.

Top module: `dual_group_divider`

## Requirements
- R1: A write to address 0 (group 0) or address 1 (group 1) sets that group's divide ratio P. The data byte is P as an unsigned integer. The legal values are 1, 2, 4, 5, 8, 10, 16, 20, 32, 40 and 80.
- R2: With ratio P, a group's counter runs from phase 0 to P-1 and then repeats. Its divided level is high while the phase is below ceil(P/2) and low for the rest of the period. With P = 1 the level is high on every cycle.
- R3: A ratio write whose data is not legal leaves both ratios and the phase of both groups unchanged. It sets a sticky error output that only reset clears.
- R4: An accepted ratio write, or any write to address 2, resynchronises both groups. In the cycle after that write edge, group 0 is at phase 0.
- R5: Address 2 holds the group 1 offset K. Take n = P1/5 and step s = 5 when P1 is a multiple of 5; otherwise take n = P1 and s = 1. In the cycle after a resync, group 1 is at phase (K mod n) × s.
- R6: Address 3 bits [4:0] enable outputs 0 to 4 (group 0). Address 4 bits [4:0] enable outputs 5 to 9 (group 1). An output whose enable is clear is low, starting from the cycle after the write edge that clears it.
- R7: A newly set enable takes effect at the first clock edge, including the write edge itself, where the group's phase wraps from P-1 to 0. Until then the output stays low.
- R8: After reset both ratios are 1, the offset is 0, all enables are clear, all outputs are low and the error flag is low.
- R9: Writes to the enable addresses and to unused addresses (5 to 7) do not change the phase of either group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; all state is clocked on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | One-cycle configuration write strobe |
| cfg_addr | input | 3 | Configuration address: 0/1 ratios, 2 offset, 3/4 enables |
| cfg_wdata | input | 8 | Configuration write data |
| clk_out | output | 10 | Divided levels; bits 4:0 are group 0, bits 9:5 are group 1 |
| cfg_err | output | 1 | Sticky flag for a rejected ratio write |

## Verification
Every result appears one cycle after the write edge. On the edge that samples the strobe, the new ratio, offset and phase are loaded, and outputs reflect them from then on. A disabled output goes low in that same following cycle. A re-enabled output rises only once the edge that restarts its group's period has passed. The bench keeps a cycle-accurate model of the phases, the enable state and the error flag, updated from the requirement rules at each edge. It compares all ten outputs and the error flag one time unit after every edge. A compare therefore always sees the values registered by the edge just before it.

// File: rtl/dgd_pkg.sv
// Shared definitions for the dual-group divider: register addresses and
// ratio arithmetic helpers. Assumes ratios fit in RATIO_W bits.
package dgd_pkg;
    localparam int RATIO_W = 8;
    localparam int ADDR_W  = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_RATIO0 = 3'd0,
        REG_RATIO1 = 3'd1,
        REG_PHASE  = 3'd2,
        REG_EN0    = 3'd3,
        REG_EN1    = 3'd4
    } cfg_reg_e;

    // True when r is one of the supported divide ratios.
    function automatic logic ratio_is_legal(input logic [RATIO_W-1:0] r);
        case (r)
            8'd1, 8'd2, 8'd4, 8'd5, 8'd8, 8'd10,
            8'd16, 8'd20, 8'd32, 8'd40, 8'd80: return 1'b1;
            default:                           return 1'b0;
        endcase
    endfunction

    // True when r is a multiple of five.
    function automatic logic is_mult5(input logic [RATIO_W-1:0] r);
        return (r % 8'd5) == 8'd0;
    endfunction

    // Number of distinct phase steps for ratio r.
    function automatic logic [RATIO_W-1:0] phase_steps(input logic [RATIO_W-1:0] r);
        return is_mult5(r) ? r / 8'd5 : r;
    endfunction

    // Length of one phase step in input cycles for ratio r.
    function automatic logic [RATIO_W-1:0] step_len(input logic [RATIO_W-1:0] r);
        return is_mult5(r) ? 8'd5 : 8'd1;
    endfunction

    // Number of high cycles per period: ceil(r/2).
    function automatic logic [RATIO_W-1:0] high_len(input logic [RATIO_W-1:0] r);
        return RATIO_W'((r + 8'd1) >> 1);
    endfunction
endpackage

// File: rtl/dgd_cfg_regs.sv
// Configuration register file. Decodes one-cycle writes, rejects illegal
// ratios (sticky error), and raises a resync pulse on every accepted ratio
// or offset write. Next-state values are exported so counters can load in
// the same edge as the registers. Assumes NOUT <= W.
module dgd_cfg_regs #(
    parameter int W    = dgd_pkg::RATIO_W,
    parameter int AW   = dgd_pkg::ADDR_W,
    parameter int NOUT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [W-1:0]      cfg_wdata,
    output logic [W-1:0]      ratio0_q,
    output logic [W-1:0]      ratio1_q,
    output logic [W-1:0]      ratio1_nxt,
    output logic [W-1:0]      phase_nxt,
    output logic [2*NOUT-1:0] en_q,
    output logic [2*NOUT-1:0] en_nxt,
    output logic              resync,
    output logic              cfg_err
);
    import dgd_pkg::*;

    logic [W-1:0] ratio0_nxt;
    logic [W-1:0] phase_q;
    logic         err_set;

    // Decode the write into next-state values, resync and error requests.
    always_comb begin
        ratio0_nxt = ratio0_q;
        ratio1_nxt = ratio1_q;
        phase_nxt  = phase_q;
        en_nxt     = en_q;
        resync     = 1'b0;
        err_set    = 1'b0;
        if (cfg_we) begin
            case (cfg_addr)
                AW'(REG_RATIO0): begin
                    if (ratio_is_legal(cfg_wdata)) begin
                        ratio0_nxt = cfg_wdata;
                        resync     = 1'b1;
                    end else begin
                        err_set = 1'b1;
                    end
                end
                AW'(REG_RATIO1): begin
                    if (ratio_is_legal(cfg_wdata)) begin
                        ratio1_nxt = cfg_wdata;
                        resync     = 1'b1;
                    end else begin
                        err_set = 1'b1;
                    end
                end
                AW'(REG_PHASE): begin
                    phase_nxt = cfg_wdata;
                    resync    = 1'b1;
                end
                AW'(REG_EN0): en_nxt[NOUT-1:0]      = cfg_wdata[NOUT-1:0];
                AW'(REG_EN1): en_nxt[2*NOUT-1:NOUT] = cfg_wdata[NOUT-1:0];
                default: ;
            endcase
        end
    end

    // Register the configuration and accumulate the sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio0_q <= W'(1);
            ratio1_q <= W'(1);
            phase_q  <= '0;
            en_q     <= '0;
            cfg_err  <= 1'b0;
        end else begin
            ratio0_q <= ratio0_nxt;
            ratio1_q <= ratio1_nxt;
            phase_q  <= phase_nxt;
            en_q     <= en_nxt;
            cfg_err  <= cfg_err | err_set;
        end
    end

    assert_ratio_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_is_legal(ratio0_q) && ratio_is_legal(ratio1_q));

    assert_illegal_keeps_ratio_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == AW'(REG_RATIO0) && !ratio_is_legal(cfg_wdata))
        |=> (ratio0_q == $past(ratio0_q)));

    assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);
endmodule

// File: rtl/dgd_phase_calc.sv
// Combinational preload for the offset group: (offset mod n) * step, where
// n and step follow the multiple-of-five rule for the group's ratio.
// Assumes ratio is legal, so n is never zero for real configurations.
module dgd_phase_calc #(
    parameter int W = dgd_pkg::RATIO_W
) (
    input  logic [W-1:0] ratio,
    input  logic [W-1:0] offset,
    output logic [W-1:0] preload
);
    import dgd_pkg::*;

    logic [W-1:0] n_steps;
    logic [W-1:0] step;
    logic [W-1:0] idx;

    // Fold the offset into range and scale it to input cycles.
    always_comb begin
        n_steps = phase_steps(ratio);
        step    = step_len(ratio);
        idx     = (n_steps == '0) ? '0 : offset % n_steps;
        preload = W'(idx * step);
    end
endmodule

// File: rtl/dgd_group_counter.sv
// Phase counter for one output group. Counts 0..ratio-1, produces the
// divided level (high for ceil(ratio/2) cycles) and a wrap flag. A sync
// pulse loads the preload phase. Assumes ratio only changes with sync.
module dgd_group_counter #(
    parameter int W = dgd_pkg::RATIO_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ratio,
    input  logic         sync,
    input  logic [W-1:0] preload,
    output logic         lvl,
    output logic         wrap
);
    import dgd_pkg::*;

    logic [W-1:0] cnt;

    // Decode the wrap point and the high portion of the period.
    always_comb begin
        wrap = (cnt == W'(ratio - W'(1)));
        lvl  = (cnt < high_len(ratio));
    end

    // Advance the phase, restart at the wrap, load on resync.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (sync) cnt <= preload;
        else if (wrap) cnt <= '0;
        else           cnt <= cnt + W'(1);
    end

    assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < ratio);

    assert_wrap_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync && wrap) |=> (cnt == '0));

    assert_sync_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sync |=> (cnt == $past(preload)));
endmodule

// File: rtl/dgd_out_gate.sv
// Per-output enable gating for one group. A cleared enable drops the
// output at once; a set enable waits for the group's wrap edge so that the
// first visible pulse is a full one.
module dgd_out_gate #(
    parameter int NOUT = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NOUT-1:0] en_nxt,
    input  logic            wrap,
    input  logic            lvl,
    output logic [NOUT-1:0] out
);
    logic [NOUT-1:0] live;

    // Track which outputs are currently driving the divided level.
    always_ff @(posedge clk) begin
        if (!rst_n) live <= '0;
        else        live <= en_nxt & (live | {NOUT{wrap}});
    end

    // Gate the shared level onto each output.
    always_comb out = live & {NOUT{lvl}};

    assert_no_runt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(live & ~$past(live))) |-> $past(wrap));
endmodule

// File: rtl/dual_group_divider.sv
// Top level: two divided output groups from one input clock, with a
// programmable phase offset of group 1 against group 0, per-output enables
// and a shared resync on every ratio or offset change.
module dual_group_divider #(
    parameter int OUTS_PER_GROUP = 5,
    parameter int RATIO_W        = dgd_pkg::RATIO_W,
    parameter int ADDR_W         = dgd_pkg::ADDR_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [ADDR_W-1:0]           cfg_addr,
    input  logic [RATIO_W-1:0]          cfg_wdata,
    output logic [2*OUTS_PER_GROUP-1:0] clk_out,
    output logic                        cfg_err
);
    localparam int NGRP = 2;
    localparam int NOUT = NGRP * OUTS_PER_GROUP;

    logic [RATIO_W-1:0] ratio0_q, ratio1_q, ratio1_nxt, phase_nxt;
    logic [NOUT-1:0]    en_q, en_nxt;
    logic               resync;
    logic [RATIO_W-1:0] grp_ratio   [NGRP];
    logic [RATIO_W-1:0] grp_preload [NGRP];
    logic [RATIO_W-1:0] preload1;

    dgd_cfg_regs #(.W(RATIO_W), .AW(ADDR_W), .NOUT(OUTS_PER_GROUP)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .ratio0_q   (ratio0_q),
        .ratio1_q   (ratio1_q),
        .ratio1_nxt (ratio1_nxt),
        .phase_nxt  (phase_nxt),
        .en_q       (en_q),
        .en_nxt     (en_nxt),
        .resync     (resync),
        .cfg_err    (cfg_err)
    );

    dgd_phase_calc #(.W(RATIO_W)) u_phase (
        .ratio   (ratio1_nxt),
        .offset  (phase_nxt),
        .preload (preload1)
    );

    // Collect per-group ratio and preload; group 0 is the phase reference.
    always_comb begin
        grp_ratio[0]   = ratio0_q;
        grp_ratio[1]   = ratio1_q;
        grp_preload[0] = '0;
        grp_preload[1] = preload1;
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic lvl;
        logic wrap;

        dgd_group_counter #(.W(RATIO_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .ratio   (grp_ratio[g]),
            .sync    (resync),
            .preload (grp_preload[g]),
            .lvl     (lvl),
            .wrap    (wrap)
        );

        dgd_out_gate #(.NOUT(OUTS_PER_GROUP)) u_gate (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_nxt (en_nxt[g*OUTS_PER_GROUP +: OUTS_PER_GROUP]),
            .wrap   (wrap),
            .lvl    (lvl),
            .out    (clk_out[g*OUTS_PER_GROUP +: OUTS_PER_GROUP])
        );
    end

    assert_preload_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        resync |-> (preload1 < ratio1_nxt));

    assert_disabled_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_out & ~en_q) == '0);
endmodule

// File: tb/dual_group_divider_test.sv
`timescale 1ns/1ps
module dual_group_divider_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_we;
    logic [2:0] cfg_addr;
    logic [7:0] cfg_wdata;
    logic [9:0] clk_out;
    logic       cfg_err;

    always #2.5 clk = ~clk;

    dual_group_divider uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .clk_out(clk_out), .cfg_err(cfg_err)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    string tag = "R8";

    // Reference state, derived from the requirement text.
    int       m_p   [2];
    int       m_pos [2];
    int       m_off;
    bit [9:0] m_req;
    bit [9:0] m_live;
    bit       m_err;

    int ratios [11] = '{1, 2, 4, 5, 8, 10, 16, 20, 32, 40, 80};

    function automatic bit legal(int v);
        foreach (ratios[i]) if (ratios[i] == v) return 1'b1;
        return 1'b0;
    endfunction
    function automatic int nst(int p); return (p % 5 == 0) ? p / 5 : p; endfunction
    function automatic int stp(int p); return (p % 5 == 0) ? 5 : 1; endfunction
    function automatic int hi(int p);  return (p + 1) / 2; endfunction

    task automatic check();
        bit [9:0] exp;
        for (int i = 0; i < 10; i++)
            exp[i] = m_live[i] && (m_pos[i/5] < hi(m_p[i/5]));
        n_chk++;
        if (clk_out !== exp || cfg_err !== m_err) begin
            n_fail++;
            $display("FAIL %s: clk_out=%b err=%b expected clk_out=%b err=%b (P0=%0d P1=%0d)",
                     tag, clk_out, cfg_err, exp, m_err, m_p[0], m_p[1]);
        end
    endtask

    // Apply one edge to the model with the inputs now driven, then compare.
    task automatic cycle();
        bit       sync = 1'b0;
        bit [9:0] req_new = m_req;
        bit [9:0] wmask;
        int       a = int'(cfg_addr);
        int       d = int'(cfg_wdata);
        for (int i = 0; i < 10; i++) wmask[i] = (m_pos[i/5] == m_p[i/5] - 1);
        if (cfg_we) begin
            case (a)
                0, 1: if (legal(d)) begin m_p[a] = d; sync = 1'b1; end else m_err = 1'b1;
                2: begin m_off = d; sync = 1'b1; end
                3: req_new[4:0] = cfg_wdata[4:0];
                4: req_new[9:5] = cfg_wdata[4:0];
                default: ;
            endcase
        end
        m_live = req_new & (m_live | wmask);
        m_req  = req_new;
        if (sync) begin
            m_pos[0] = 0;
            m_pos[1] = (m_off % nst(m_p[1])) * stp(m_p[1]);
        end else begin
            for (int g = 0; g < 2; g++) m_pos[g] = (m_pos[g] + 1) % m_p[g];
        end
        @(posedge clk);
        #1;
        check();
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic wr(int a, int d);
        cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 8'(d);
        cycle();
        cfg_we = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        m_p[0] = 1; m_p[1] = 1; m_pos[0] = 0; m_pos[1] = 0;
        m_off = 0; m_req = '0; m_live = '0; m_err = 1'b0;
        // R8: reset state seen while reset is held
        tag = "R8 reset state";
        repeat (2) begin @(posedge clk); #1; check(); end
        rst_n = 1'b1;
        run(3);

        // R6: enable every output at ratio 1 (wraps every cycle)
        tag = "R6 enable all";
        wr(3, 'h1f); wr(4, 'h1f); run(3);

        // R1 R2 R4: every pair of legal ratios
        tag = "R1 R2 R4 ratio sweep";
        foreach (ratios[i]) foreach (ratios[j]) begin
            wr(0, ratios[i]); wr(1, ratios[j]);
            run(2 * ((ratios[i] > ratios[j]) ? ratios[i] : ratios[j]) + 2);
        end

        // R5: every offset step (plus wrap-around) for each group 1 ratio
        tag = "R5 phase offset sweep";
        wr(0, 8);
        foreach (ratios[j]) begin
            wr(1, ratios[j]);
            for (int k = 0; k < nst(ratios[j]) + 2; k++) begin
                wr(2, k); run(2 * ratios[j] + 1);
            end
            wr(2, 200 + j); run(2 * ratios[j] + 1);
        end

        // R3: illegal ratio codes are rejected without a resync
        tag = "R3 illegal ratio";
        wr(2, 3); wr(0, 80); wr(1, 20); run(7);
        wr(0, 3); run(13);
        wr(1, 0); run(9);
        wr(0, 81); wr(1, 255); run(20);

        // R6 R7 R9: enables cleared and set mid-period
        tag = "R6 disable";
        wr(2, 0); wr(0, 8); wr(1, 10); run(5);
        wr(3, 'h1a); run(3);
        tag = "R7 re-enable waits for wrap";
        wr(3, 'h1f); run(20);
        wr(4, 'h00); run(4);
        wr(4, 'h15); run(25);
        tag = "R9 no resync from enable or unused writes";
        wr(5, 'h44); run(3); wr(7, 'h01); run(3);
        wr(3, 'h03); run(12);
        tag = "R7 ratio 1 enable";
        wr(0, 1); wr(3, 'h00); run(2); wr(3, 'h1f); run(4);

        summary();
        $finish;
    end
endmodule